// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block fills and moves rectangles inside a linear framebuffer in memory. Memory is reached through a byte-wide port that uses a request/acknowledge handshake. A pixel occupies one to four bytes. Pixel (x, y) lives at byte `bpp*x + bpp*scr_w*y`.

A fill writes the low `bpp` bytes of a colour word into every pixel of the rectangle. A copy moves a rectangle of pixels from a source corner to a destination corner. The copy walks rows and bytes in an order that leaves the result correct even when the source and destination overlap.

Each operation, including an empty one, appends its destination rectangle to a circular redraw queue. A flush strobe drains the queue. Each rectangle is clipped to the screen and presented as one display-update beat per cycle. If a full-screen invalidate is pending at flush time, the whole queue is dropped in a single cycle instead.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `upd_valid` and `flush_done` are all low.
- R2: The byte offset `k` (0 to `bpp*w-1`) of row `r` of a rectangle at (x, y) is at address `bpp*x + bpp*scr_w*(y+r) + k`. A request holds `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`.
- R3: A fill (`op`=0) sets byte `j` of every pixel to bits `8j+7:8j` of `colour`, for `j < bpp`. It performs exactly `bpp*w*h` writes and no reads, and it leaves all other bytes unchanged.
- R4: A copy (`op`=1) leaves the destination equal to the source as it was before the copy, even when the two rectangles overlap. It performs `bpp*w*h` reads and the same number of writes.
- R5: A copy with `dst_y > src_y` writes the bottom row first. Otherwise it writes the top row first.
- R6: A copy with `dst_x > src_x` walks each row from its highest byte downward. Otherwise it walks upward from byte 0.
- R7: An operation with `rect_w`=0 or `rect_h`=0 makes no memory access. It still completes with `done` and still queues its rectangle.
- R8: `busy` rises the cycle after an accepted `start` and stays high until the one-cycle `done` pulse. A `start` while busy is ignored.
- R9: After each operation, (`dst_x`, `dst_y`, `rect_w`, `rect_h`) is queued. A flush without a pending invalidate issues the queued rectangles in order, one `upd_valid` beat per rectangle. It then pulses `flush_done`.
- R10: On issue, when `x + w > scr_w`, x becomes `min(x, scr_w)` and w becomes `scr_w - x`. The y and h fields are clipped the same way against `scr_h`.
- R11: A flush with `inv_pend` high issues no update, empties the queue and pulses `flush_done`.
- R12: The queue holds 512 entries and its indices wrap modulo 512. After 515 pushes on an empty queue, a flush issues only the last three rectangles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scr_w | input | 12 | Screen width in pixels |
| scr_h | input | 12 | Screen height in pixels |
| bpp | input | 3 | Bytes per pixel, 1 to 4 |
| start | input | 1 | Begin an operation |
| op | input | 1 | 0 = fill, 1 = copy |
| colour | input | 32 | Fill colour, little-endian bytes |
| src_x | input | 12 | Copy source x |
| src_y | input | 12 | Copy source y |
| dst_x | input | 12 | Destination x |
| dst_y | input | 12 | Destination y |
| rect_w | input | 12 | Rectangle width in pixels |
| rect_h | input | 12 | Rectangle height in pixels |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| flush | input | 1 | Drain the redraw queue |
| inv_pend | input | 1 | Full invalidate pending: discard on flush |
| upd_valid | output | 1 | Update rectangle beat |
| upd_x | output | 12 | Clipped update x |
| upd_y | output | 12 | Clipped update y |
| upd_w | output | 12 | Clipped update width |
| upd_h | output | 12 | Clipped update height |
| flush_done | output | 1 | Flush finished pulse |

## Verification
Some properties are checked by assertions on every cycle:
- a pending memory request holds its address, direction and data;
- a fill never issues a read;
- `done` lasts exactly one cycle and `busy` holds until it;
- the queue write index moves by one per push and only on a push;
- every issued update lies within the screen;
- a discarding flush issues no update.

Other behaviour can only be shown by the bench's scenarios:
- the framebuffer contents after a fill or an overlapping copy;
- the first address written, which shows row and byte order;
- the exact read and write counts;
- the issue order of rectangles, and the wrap of the queue after 515 pushes.

// File: rtl/blit_pkg.sv
package blit_pkg;
  parameter int COORD_W = 12;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
    coord_t w;
    coord_t h;
  } rect_t;

  typedef enum logic {
    OP_FILL = 1'b0,
    OP_COPY = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } eng_st_e;

  // Clip one axis: returns {pos, len}
  function automatic logic [2*COORD_W-1:0] clip_axis(coord_t pos, coord_t len, coord_t lim);
    logic [COORD_W:0] end_v;
    coord_t cp;
    coord_t cl;
    end_v = {1'b0, pos} + {1'b0, len};
    if (end_v > {1'b0, lim}) begin
      cp = (pos < lim) ? pos : lim;
      cl = lim - cp;
    end else begin
      cp = pos;
      cl = len;
    end
    return {cp, cl};
  endfunction
endpackage

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = COORD_W + 3
) (
  input  logic [2:0]    bpp,
  input  coord_t        scr_w,
  input  coord_t        x,
  input  coord_t        y,
  input  logic [LW-1:0] off,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] bpp_w;
  logic [AW-1:0] pitch;

  assign bpp_w = AW'(bpp);
  assign pitch = bpp_w * AW'(scr_w);
  assign addr  = bpp_w * AW'(x) + pitch * AW'(y) + AW'(off);
endmodule

// File: rtl/blit_core.sv
module blit_core
  import blit_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op,
  input  logic [31:0]   colour,
  input  coord_t        src_x,
  input  coord_t        src_y,
  input  coord_t        dst_x,
  input  coord_t        dst_y,
  input  coord_t        rect_w,
  input  coord_t        rect_h,
  input  logic [2:0]    bpp,
  input  coord_t        scr_w,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          push,
  output rect_t         push_rect
);
  localparam int LW = COORD_W + 3;
  localparam int NPORT = 2;  // 0 = source, 1 = destination

  eng_st_e       st_q, st_d;
  logic [LW-1:0] cc_q, cc_d;
  coord_t        rc_q, rc_d;
  logic [1:0]    ph_q, ph_d;
  logic [7:0]    rb_q, rb_d;

  op_e           op_q;
  logic [31:0]   col_q;
  coord_t        sx_q, sy_q, dx_q, dy_q, w_q, h_q, pw_q;
  logic [2:0]    bpp_q;
  logic          bu_q, rl_q;
  logic [LW-1:0] len_q;

  logic          ld_en;
  logic          zero_sz;
  coord_t        row_act;
  logic [LW-1:0] col_act;
  logic          col_last, row_last;
  eng_st_e       st_after;

  coord_t        ag_x   [NPORT];
  coord_t        ag_y   [NPORT];
  logic [AW-1:0] ag_addr[NPORT];

  assign ld_en    = (st_q == ST_IDLE) && start;
  assign zero_sz  = (rect_w == '0) || (rect_h == '0);
  assign row_act  = bu_q ? coord_t'(h_q - coord_t'(1) - rc_q) : rc_q;
  assign col_act  = rl_q ? (len_q - LW'(1) - cc_q) : cc_q;
  assign col_last = (cc_q == len_q - LW'(1));
  assign row_last = (rc_q == h_q - coord_t'(1));
  assign st_after = (op_q == OP_COPY) ? ST_READ : ST_WRITE;

  assign ag_x[0] = sx_q;
  assign ag_y[0] = coord_t'(sy_q + row_act);
  assign ag_x[1] = dx_q;
  assign ag_y[1] = coord_t'(dy_q + row_act);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    blit_addr_gen #(.AW(AW), .LW(LW)) u_ag (
      .bpp  (bpp_q),
      .scr_w(pw_q),
      .x    (ag_x[p]),
      .y    (ag_y[p]),
      .off  (col_act),
      .addr (ag_addr[p])
    );
  end

  // Next-state logic
  always_comb begin
    st_d = st_q;
    cc_d = cc_q;
    rc_d = rc_q;
    ph_d = ph_q;
    rb_d = rb_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cc_d = '0;
          rc_d = '0;
          ph_d = '0;
          if (zero_sz)           st_d = ST_FIN;
          else if (op == 1'b1)   st_d = ST_READ;
          else                   st_d = ST_WRITE;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          rb_d = mem_rdata;
          st_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (col_last) begin
            cc_d = '0;
            ph_d = '0;
            if (row_last) begin
              st_d = ST_FIN;
            end else begin
              rc_d = rc_q + coord_t'(1);
              st_d = st_after;
            end
          end else begin
            cc_d = cc_q + LW'(1);
            ph_d = ({1'b0, ph_q} == bpp_q - 3'd1) ? 2'd0 : ph_q + 2'd1;
            st_d = st_after;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      cc_q <= '0;
      rc_q <= '0;
      ph_q <= '0;
      rb_q <= '0;
    end else begin
      st_q <= st_d;
      cc_q <= cc_d;
      rc_q <= rc_d;
      ph_q <= ph_d;
      rb_q <= rb_d;
    end
  end

  // Operand latch, enabled on an accepted start
  always_ff @(posedge clk) begin
    if (ld_en) begin
      op_q  <= op_e'(op);
      col_q <= colour;
      sx_q  <= src_x;
      sy_q  <= src_y;
      dx_q  <= dst_x;
      dy_q  <= dst_y;
      w_q   <= rect_w;
      h_q   <= rect_h;
      pw_q  <= scr_w;
      bpp_q <= bpp;
      len_q <= LW'(bpp) * LW'(rect_w);
      bu_q  <= op && (dst_y > src_y);
      rl_q  <= op && (dst_x > src_x);
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we    = (st_q == ST_WRITE);
  assign mem_addr  = (st_q == ST_READ) ? ag_addr[0] : ag_addr[1];
  assign mem_wdata = (op_q == OP_FILL) ? col_q[{ph_q, 3'b000} +: 8] : rb_q;
  assign push      = (st_q == ST_FIN);
  assign push_rect = '{x: dx_q, y: dy_q, w: w_q, h: h_q};

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_fill_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_q == OP_FILL) |-> mem_we);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/redraw_queue.sv
module redraw_queue
  import blit_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  rect_t push_rect,
  input  logic  pop,
  input  logic  discard,
  output logic  empty,
  output rect_t head
);
  localparam int PW = $clog2(DEPTH);

  rect_t         slot [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push)         wr_d = wr_q + PW'(1);
    if (discard)      rd_d = wr_q;
    else if (pop)     rd_d = rd_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_q] <= push_rect;
  end

  assign empty = (rd_q == wr_q);
  assign head  = slot[rd_q];

  assert_wr_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (wr_q == $past(wr_q) + PW'(1)));

  assert_wr_still_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(wr_q));
endmodule

// File: rtl/update_issuer.sv
module update_issuer
  import blit_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   inv_pend,
  input  coord_t scr_w,
  input  coord_t scr_h,
  input  logic   empty,
  input  rect_t  head,
  output logic   pop,
  output logic   discard,
  output logic   upd_valid,
  output rect_t  upd_rect,
  output logic   flush_done
);
  logic  drain_q, drain_d;
  logic  val_q, val_d;
  rect_t rect_q, rect_d;
  logic  fd_q, fd_d;
  logic [2*COORD_W-1:0] cx, cy;

  assign cx      = clip_axis(head.x, head.w, scr_w);
  assign cy      = clip_axis(head.y, head.h, scr_h);
  assign pop     = drain_q && !empty;
  assign discard = !drain_q && flush && inv_pend;

  always_comb begin
    drain_d = drain_q;
    val_d   = pop;
    rect_d  = rect_q;
    fd_d    = discard;
    if (pop) begin
      rect_d = '{x: cx[2*COORD_W-1:COORD_W], y: cy[2*COORD_W-1:COORD_W],
                 w: cx[COORD_W-1:0],         h: cy[COORD_W-1:0]};
    end
    if (!drain_q && flush && !inv_pend) drain_d = 1'b1;
    if (drain_q && empty) begin
      drain_d = 1'b0;
      fd_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      val_q   <= 1'b0;
      fd_q    <= 1'b0;
    end else begin
      drain_q <= drain_d;
      val_q   <= val_d;
      fd_q    <= fd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) rect_q <= rect_d;
  end

  assign upd_valid  = val_q;
  assign upd_rect   = rect_q;
  assign flush_done = fd_q;

  assert_clip_in_screen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (({1'b0, upd_rect.x} + {1'b0, upd_rect.w} <= {1'b0, scr_w}) &&
                   ({1'b0, upd_rect.y} + {1'b0, upd_rect.h} <= {1'b0, scr_h})));

  assert_discard_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && inv_pend && !drain_q) |=> !upd_valid);
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int AW     = 24,
  parameter int QDEPTH = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] scr_w,
  input  logic [COORD_W-1:0] scr_h,
  input  logic [2:0]         bpp,
  input  logic               start,
  input  logic               op,
  input  logic [31:0]        colour,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  output logic               busy,
  output logic               done,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic               mem_ack,
  input  logic [7:0]         mem_rdata,
  input  logic               flush,
  input  logic               inv_pend,
  output logic               upd_valid,
  output logic [COORD_W-1:0] upd_x,
  output logic [COORD_W-1:0] upd_y,
  output logic [COORD_W-1:0] upd_w,
  output logic [COORD_W-1:0] upd_h,
  output logic               flush_done
);
  logic  push, pop, discard, empty;
  rect_t push_rect, head, upd_rect;

  blit_core #(.AW(AW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .colour   (colour),
    .src_x    (src_x),
    .src_y    (src_y),
    .dst_x    (dst_x),
    .dst_y    (dst_y),
    .rect_w   (rect_w),
    .rect_h   (rect_h),
    .bpp      (bpp),
    .scr_w    (scr_w),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .push     (push),
    .push_rect(push_rect)
  );

  redraw_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_rect(push_rect),
    .pop      (pop),
    .discard  (discard),
    .empty    (empty),
    .head     (head)
  );

  update_issuer u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .inv_pend  (inv_pend),
    .scr_w     (scr_w),
    .scr_h     (scr_h),
    .empty     (empty),
    .head      (head),
    .pop       (pop),
    .discard   (discard),
    .upd_valid (upd_valid),
    .upd_rect  (upd_rect),
    .flush_done(flush_done)
  );

  assign upd_x = upd_rect.x;
  assign upd_y = upd_rect.y;
  assign upd_w = upd_rect.w;
  assign upd_h = upd_rect.h;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !mem_req && !upd_valid));
endmodule

// File: tb/rect_blit_engine_bench.sv
module rect_blit_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 32;
  localparam int SH = 16;
  localparam int MEMB = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] scr_w = 12'(SW), scr_h = 12'(SH);
  logic [2:0]  bpp = 3'd1;
  logic        start = 1'b0, op = 1'b0;
  logic [31:0] colour = '0;
  logic [11:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
  logic        busy, done, mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        flush = 1'b0, inv_pend = 1'b0;
  logic        upd_valid, flush_done;
  logic [11:0] upd_x, upd_y, upd_w, upd_h;

  rect_blit_engine u_rect_blit_engine (
    .clk(clk), .rst_n(rst_n), .scr_w(scr_w), .scr_h(scr_h), .bpp(bpp),
    .start(start), .op(op), .colour(colour), .src_x(src_x), .src_y(src_y),
    .dst_x(dst_x), .dst_y(dst_y), .rect_w(rect_w), .rect_h(rect_h),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .flush(flush), .inv_pend(inv_pend),
    .upd_valid(upd_valid), .upd_x(upd_x), .upd_y(upd_y), .upd_w(upd_w),
    .upd_h(upd_h), .flush_done(flush_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model, answers away from the active edge
  logic [7:0] mem [MEMB];
  int nwr = 0;
  int nrd = 0;
  int wlog [65536];
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 37 + 11);
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] = mem_wdata;
        wlog[nwr % 65536] = int'(mem_addr);
        nwr = nwr + 1;
      end else begin
        mem_rdata = mem[mem_addr[11:0]];
        nrd = nrd + 1;
      end
      mem_ack = 1'b1;
    end
  end

  int total = 0;
  int bad = 0;
  logic [7:0] sh [MEMB];
  int eqx [512], eqy [512], eqw [512], eqh [512];
  int ewr = 0, erd = 0;
  int gx [1024], gy [1024], gw [1024], gh [1024];
  int gn;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void clipf(input int p, input int l, input int lim, output int cp, output int cl);
    if (p + l > lim) begin
      cp = (p < lim) ? p : lim;
      cl = lim - cp;
    end else begin
      cp = p;
      cl = l;
    end
  endfunction

  task automatic q_push(input int x, input int y, input int w, input int h);
    eqx[ewr] = x; eqy[ewr] = y; eqw[ewr] = w; eqh[ewr] = h;
    ewr = (ewr + 1) % 512;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, req, "done seen", int'(done), 1);
  endtask

  // Run one operation; optional second start while busy (must be ignored)
  task automatic run_op(input bit cp, input int b, input logic [31:0] c,
                        input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input bit poke, input bit quiet);
    int w0, r0;
    int len, pitch, fa, erow, ecol;
    logic [7:0] tmp [MEMB];
    w0 = nwr; r0 = nrd;
    @(negedge clk);
    bpp = 3'(b); op = cp; colour = c;
    src_x = 12'(sx); src_y = 12'(sy); dst_x = 12'(dx); dst_y = 12'(dy);
    rect_w = 12'(w); rect_h = 12'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!quiet) chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      colour = ~c; dst_x = 12'(dx + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done("R8");
    @(negedge clk);
    if (!quiet) chk(!done && !busy, "R8", "done one cycle", int'(done), 0);
    // Expected framebuffer
    len = b * w; pitch = b * SW;
    for (int i = 0; i < MEMB; i++) tmp[i] = sh[i];
    for (int r = 0; r < h; r++)
      for (int k = 0; k < len; k++) begin
        if (cp) sh[b*dx + pitch*(dy+r) + k] = tmp[b*sx + pitch*(sy+r) + k];
        else    sh[b*dx + pitch*(dy+r) + k] = c[8*(k % b) +: 8];
      end
    q_push(dx, dy, w, h);
    if (quiet) return;
    begin
      int mism = 0;
      for (int i = 0; i < MEMB; i++) if (mem[i] !== sh[i]) mism++;
      chk(mism == 0, cp ? "R4" : "R3", "mismatching bytes", mism, 0);
    end
    chk(nwr - w0 == len * h, (w == 0 || h == 0) ? "R7" : "R2", "write count", nwr - w0, len * h);
    chk(nrd - r0 == (cp ? len * h : 0), cp ? "R4" : "R3", "read count", nrd - r0, cp ? len * h : 0);
    if (len * h > 0) begin
      erow = (cp && dy > sy) ? dy + h - 1 : dy;
      ecol = (cp && dx > sx) ? len - 1 : 0;
      fa = b * dx + pitch * erow + ecol;
      chk(wlog[w0 % 65536] == fa, cp ? "R5" : "R2", "first write address", wlog[w0 % 65536], fa);
    end
  endtask

  task automatic run_flush(input bit inv, input string req);
    int n = 0;
    gn = 0;
    @(negedge clk);
    inv_pend = inv; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    while (n < 5000) begin
      if (upd_valid) begin
        gx[gn] = int'(upd_x); gy[gn] = int'(upd_y); gw[gn] = int'(upd_w); gh[gn] = int'(upd_h);
        gn++;
      end
      if (flush_done) break;
      @(negedge clk);
      n++;
    end
    chk(flush_done, req, "flush_done seen", int'(flush_done), 1);
    inv_pend = 1'b0;
    if (inv) begin
      chk(gn == 0, "R11", "updates on discard", gn, 0);
      erd = ewr;
    end else begin
      int cnt = 0;
      int ok = 1;
      while (erd != ewr) begin
        int cx, cw, cy, ch;
        clipf(eqx[erd], eqw[erd], SW, cx, cw);
        clipf(eqy[erd], eqh[erd], SH, cy, ch);
        if (cnt >= gn || gx[cnt] != cx || gw[cnt] != cw || gy[cnt] != cy || gh[cnt] != ch) ok = 0;
        cnt++;
        erd = (erd + 1) % 512;
      end
      chk(gn == cnt, req, "update count", gn, cnt);
      chk(ok == 1, req, "update rectangles in order", ok, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < MEMB; i++) sh[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_req && !upd_valid && !flush_done, "R1", "outputs in reset",
        int'({busy, done, mem_req, upd_valid, flush_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !upd_valid, "R1", "outputs after reset",
        int'({busy, mem_req, upd_valid}), 0);

    // Directed fills, each pixel size (R3, R2)
    run_op(0, 1, 32'hA1B2C3D4, 0, 0, 3, 2, 5, 3, 0, 0);
    run_op(0, 2, 32'h11223344, 0, 0, 0, 0, 4, 2, 0, 0);
    run_op(0, 3, 32'hDEADBEEF, 0, 0, 10, 5, 3, 4, 0, 0);
    run_op(0, 4, 32'h01020304, 0, 0, 28, 15, 4, 1, 0, 0);
    run_flush(0, "R9");

    // Overlapping copies: R5 bottom-up + R6 descending
    run_op(1, 3, 0, 4, 2, 6, 4, 6, 5, 0, 0);
    // same row, leftward: top-down, ascending (R6)
    run_op(1, 2, 0, 5, 7, 2, 7, 7, 3, 0, 0);
    // upward and rightward: top-down, descending (R5, R6)
    run_op(1, 4, 0, 2, 6, 5, 3, 5, 4, 0, 0);
    // identical position
    run_op(1, 1, 0, 7, 3, 7, 3, 4, 4, 0, 0);
    run_flush(0, "R9");

    // R7: empty rectangles; R10: clipping on issue
    run_op(0, 2, 32'hFFFFFFFF, 0, 0, 10, 2, 40, 0, 0, 0);
    run_op(0, 2, 32'hFFFFFFFF, 0, 0, 40, 3, 5, 0, 0, 0);
    run_op(1, 1, 0, 0, 0, 4, 5, 0, 20, 0, 0);
    run_op(1, 1, 0, 0, 0, 6, 20, 0, 3, 0, 0);
    run_flush(0, "R10");

    // R8: start while busy ignored
    run_op(0, 2, 32'h0000BEEF, 0, 0, 8, 8, 4, 2, 1, 0);
    run_flush(0, "R8");

    // R11: discard with pending invalidate, then nothing left
    run_op(0, 1, 32'h5A, 0, 0, 1, 1, 2, 2, 0, 0);
    run_op(1, 1, 0, 1, 1, 3, 3, 2, 2, 0, 0);
    run_flush(1, "R11");
    run_flush(0, "R11");

    // Random operations
    for (int it = 0; it < 24; it++) begin
      int b, w, h, sx, sy, dx, dy;
      bit cp;
      b  = 1 + int'($urandom % 4);
      w  = 1 + int'($urandom % 8);
      h  = 1 + int'($urandom % 6);
      sx = int'($urandom % (SW - w + 1));
      sy = int'($urandom % (SH - h + 1));
      dx = int'($urandom % (SW - w + 1));
      dy = int'($urandom % (SH - h + 1));
      cp = 1'($urandom % 2);
      run_op(cp, b, $urandom, sx, sy, dx, dy, w, h, 0, 0);
      if (it % 6 == 5) run_flush(0, "R9");
    end
    run_flush(0, "R9");

    // R12: 515 pushes wrap the 512-entry queue
    for (int i = 0; i < 515; i++)
      run_op(0, 1, 0, 0, 0, i % 32, (i / 32) % 16, 0, 0, 0, 1);
    erd = (ewr + 509) % 512;
    run_flush(0, "R12");
    chk(gn == 3 && gx[0] == 0 && gx[2] == 2, "R12", "last three after wrap", gn, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule